// File: doc/BRIEF.md
# Gated-clock parallel-load shift register

This block is a parallel-in, serial-out shift register with eight stages by default. An active-low load input copies a parallel word into every stage. Two clock inputs feed a shared gate, so either one can act as the shift clock while the other blocks clocking. The stage at the far end of the chain drives a true serial output and a complementary serial output.

The whole design runs from one fast system clock. The two clock inputs are sampled as plain data signals. Their OR is registered, and a rising edge of that combined signal is detected synchronously. A detected edge moves the contents one place along the chain, with the serial input entering the first stage. Load is level-sensitive and always wins over shifting.

The block has no valid/ready handshake and applies no back-pressure. It accepts every load level and every detected clock edge in the cycle it arrives.

Top module: `gated_piso_shreg`

## Requirements
- R1: While `rst` is high, every stage clears to 0. One cycle later `ser_out` reads 0 and `ser_out_n` reads 1, and leaving reset produces no shift.
- R2: While `load_n` is low, every stage takes its `par_in` bit at each system clock edge. Stage index 0 (the first stage) takes `par_in[0]`, and the last stage takes `par_in[WIDTH-1]`. `ser_out` therefore shows `par_in[WIDTH-1]` after one edge.
- R3: A rising edge of (`clk_a` OR `clk_b`) with `load_n` high moves `ser_in` into stage 0 and stage i-1 into stage i. The stages change on the second system-clock edge that samples the combined clock high.
- R4: While either clock input is held high, transitions on the other input cause no shift.
- R5: Either input can serve as the shift clock while the other is held low.
- R6: Load overrides clocking. Edges seen while `load_n` is low cause no shift. An edge sampled in the last cycle before `load_n` is released is discarded, so the first shift after a load needs a new rising edge.
- R7: `ser_out` equals the last stage, and `ser_out_n` is always its complement.
- R8: Exactly one shift happens per rising edge of the combined clock, however long the combined clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_a | input | 1 | First gated clock input (clock or inhibit) |
| clk_b | input | 1 | Second gated clock input (clock or inhibit) |
| load_n | input | 1 | Active-low parallel load, level-sensitive |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel word, bit i goes to stage i |
| ser_out | output | 1 | True serial output from the last stage |
| ser_out_n | output | 1 | Complementary serial output |

## Verification
The bench builds the block with its default `WIDTH` of 8. At that width, a full drain of a loaded word and a full refill from the serial input both fit in eight clock pulses, so every stage is observed at the output. Within each vector the clock roles alternate between the two inputs. Directed cases then hold each input high as an inhibit, keep the combined clock high for a long stretch, and release load while a clock edge is still pending.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;
endpackage

// File: rtl/psr_clk_merge.sv
// Merges the two gated clock inputs and finds rising edges of their OR.
module psr_clk_merge (
  input  logic clk,
  input  logic rst,
  input  logic clk_a,
  input  logic clk_b,
  output logic rise
);
  logic comb_q;
  logic prev_q;

  // Both registers reset high, so the first cycles after reset never look like an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      comb_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      comb_q <= clk_a | clk_b;
      prev_q <= comb_q;
    end
  end

  assign rise = comb_q & ~prev_q;

  // R8: a detected edge lasts a single cycle.
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/psr_stage_chain.sv
// The register stages: parallel load, shift toward the last stage, or hold.
module psr_stage_chain
  import psr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stage_op_e        op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stages
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shift_src;
    if (i == 0) begin : g_head
      assign shift_src = ser_in;
    end else begin : g_body
      assign shift_src = stages[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stages[i] <= 1'b0;
      end else begin
        unique case (op)
          OP_LOAD:  stages[i] <= par_in[i];
          OP_SHIFT: stages[i] <= shift_src;
          default:  stages[i] <= stages[i];
        endcase
      end
    end
  end

  // R3: a shift moves the serial bit into stage 0 and every other bit up one place.
  a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});
endmodule

// File: rtl/gated_piso_shreg.sv
// Top level: combines the edge detector, the load/shift decode and the stage chain.
module gated_piso_shreg
  import psr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int LAST = WIDTH - 1;

  logic             rise;
  logic             load_n_q;
  logic             shift_en;
  stage_op_e        op;
  logic [WIDTH-1:0] stages;

  psr_clk_merge u_merge (
    .clk   (clk),
    .rst   (rst),
    .clk_a (clk_a),
    .clk_b (clk_b),
    .rise  (rise)
  );

  // Remembers the previous load level, so an edge that overlapped the load is dropped.
  always_ff @(posedge clk) begin
    if (rst) load_n_q <= 1'b1;
    else     load_n_q <= load_n;
  end

  assign shift_en = rise & load_n & load_n_q;

  always_comb begin
    if (!load_n)       op = OP_LOAD;
    else if (shift_en) op = OP_SHIFT;
    else               op = OP_HOLD;
  end

  psr_stage_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .ser_in (ser_in),
    .par_in (par_in),
    .stages (stages)
  );

  assign ser_out   = stages[LAST];
  assign ser_out_n = ~stages[LAST];

  // R1: reset leaves a cleared chain at the outputs.
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (stages == '0 && !ser_out && ser_out_n));

  // R2: a low load level copies the parallel word.
  a_r2_load_copy: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> stages == $past(par_in));

  // R4: a combined clock that stayed high over two samples yields no shift.
  a_r4_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(clk_a | clk_b) && $past(clk_a | clk_b, 2)) |-> !shift_en);
endmodule

// File: tb/gated_piso_shreg_test.sv
module gated_piso_shreg_test;
  localparam int W = 8;

  // Each entry: parallel word in the upper byte, serial fill bits in the lower byte.
  localparam logic [15:0] VEC [4] = '{16'hA5_3C, 16'h0F_F0, 16'hFF_00, 16'h96_5A};

  logic clk = 1'b0;
  logic rst, clk_a, clk_b, load_n, ser_in;
  logic [W-1:0] par_in;
  logic ser_out, ser_out_n;

  logic [W-1:0] m;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gated_piso_shreg #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .clk_a(clk_a), .clk_b(clk_b), .load_n(load_n),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check_out(input string tag);
    check(ser_out, m[W-1], tag);
    check(ser_out_n, ~m[W-1], {tag, " R7 complement"});
  endtask

  task automatic do_load(input logic [W-1:0] p);
    par_in = p; load_n = 1'b0;
    tick(1);
    load_n = 1'b1;
    tick(1);
    m = p;
  endtask

  task automatic pulse(input bit use_b, input logic s);
    ser_in = s;
    if (use_b) clk_b = 1'b1; else clk_a = 1'b1;
    tick(3);
    clk_a = 1'b0; clk_b = 1'b0;
    tick(3);
    m = {m[W-2:0], s};
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clk_a = 1'b1; clk_b = 1'b0; load_n = 1'b1; ser_in = 1'b1; par_in = '0;
    tick(3);
    m = '0;
    check_out("R1 reset");
    rst = 1'b0;
    tick(4);
    clk_a = 1'b0;
    tick(3);
    check_out("R1 no shift leaving reset");

    // Vector walk: load, then eight shifts alternating the two clock inputs.
    for (int v = 0; v < 4; v++) begin
      do_load(VEC[v][15:8]);
      check_out("R2 load");
      for (int k = 0; k < W; k++) begin
        pulse(((k + v) % 2) == 1, VEC[v][W-1-k]);
        check_out((((k + v) % 2) == 1) ? "R3 R5 shift via clk_b" : "R3 R5 shift via clk_a");
      end
      check(m == VEC[v][7:0], 1'b1, "R3 serial fill model");
    end

    // R4: clk_b held high as an inhibit while clk_a toggles.
    do_load(8'b1010_1010);
    ser_in = 1'b0;
    clk_a = 1'b1; tick(3);
    m = {m[W-2:0], 1'b0};
    clk_b = 1'b1; tick(1);
    for (int t = 0; t < 4; t++) begin
      clk_a = 1'b0; tick(3);
      clk_a = 1'b1; tick(3);
    end
    check_out("R4 inhibit by clk_b");
    // R4 swapped: clk_a held high while clk_b toggles.
    for (int t = 0; t < 4; t++) begin
      clk_b = 1'b0; tick(3);
      clk_b = 1'b1; tick(3);
    end
    check_out("R4 inhibit by clk_a");
    clk_a = 1'b0; clk_b = 1'b0; tick(3);
    check_out("R4 release causes no shift");

    // R6: clock edges during a held load are ignored.
    par_in = 8'h80; load_n = 1'b0;
    for (int t = 0; t < 3; t++) begin
      clk_a = 1'b1; tick(3);
      clk_a = 1'b0; tick(3);
    end
    load_n = 1'b1; tick(3);
    m = 8'h80;
    check_out("R6 edges during load");

    // R6: edge sampled in the last load cycle is dropped after release.
    par_in = 8'h80; load_n = 1'b0; tick(2);
    clk_a = 1'b1; tick(1);
    load_n = 1'b1; tick(4);
    m = 8'h80;
    check_out("R6 stale edge dropped");
    clk_a = 1'b0; tick(3);
    pulse(1'b0, 1'b0);
    check_out("R6 fresh edge shifts");

    // R8: a long high combined clock gives one shift only.
    do_load(8'b1100_0000);
    ser_in = 1'b0;
    clk_b = 1'b1; tick(20);
    m = {m[W-2:0], 1'b0};
    check_out("R8 one shift per edge");
    clk_b = 1'b0; tick(3);
    pulse(1'b1, 1'b0);
    check_out("R8 next edge shifts");

    // R1: reset in mid-use clears the chain.
    do_load(8'hFF);
    rst = 1'b1; tick(2);
    rst = 1'b0; tick(1);
    m = '0;
    check_out("R1 reset after use");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule